// File: doc/BRIEF.md
# Configuration-Aware Reset Sequencer

This block produces the system reset for fabric logic on a device that leaves configuration region by region. Some registers can start running while nearby logic is still frozen. The block takes two inputs. The first is an active-high "configuration still in progress" flag from the device's configuration controller. The second is the lock indication of the clock PLL.

The block drives two outputs:

- **PLL reset.** It follows the configuration flag, so the PLL cannot begin locking until the whole fabric is live.
- **System reset.** Logic that would depend on power-up register values depends on this reset instead.

The system reset asserts asynchronously the moment either condition fails, that is, configuration still in progress or PLL lock lost. It is released only after both conditions hold. The release passes through three stages, all in the user clock domain:

1. A two-flop synchronizer for the lock input.
2. A two-flop deassertion synchronizer.
3. A programmable stretch of `STRETCH_CYCLES` clock cycles.

If lock drops later, the reset asserts again at once, and the whole release sequence starts over when lock returns. No register in the block relies on a power-up value. Every state element is forced by the configuration flag or by the loss of lock.

The block carries no data stream: all pins are plain control levels with no handshake.

Top module: `cfg_reset_seq`

## Requirements
- R1: `pll_rst` equals `cfg_busy` at all times, with no clock delay.
- R2: While `cfg_busy` is 1, `sys_rst` is 1.
- R3: While `pll_locked` is 0, `sys_rst` is 1.
- R4: `pll_locked` at 1 while `cfg_busy` is still 1 never releases `sys_rst`.
- R5: Assertion of `sys_rst` is asynchronous. It reaches 1 within the same clock period in which `cfg_busy` rises or `pll_locked` falls, before the next rising edge of `clk`.
- R6: Once `cfg_busy` is 0 and `pll_locked` is 1 together, `sys_rst` falls on a rising edge of `clk`. That edge is the (STRETCH_CYCLES + 4)th rising edge at which both conditions hold, which is the 20th edge with the defaults. The count assumes the preceding not-ready interval lasted at least 3 clock cycles.
- R7: A loss of lock after release re-asserts `sys_rst` and restarts the full R6 count when lock returns.
- R8: No behaviour depends on register power-up values. After `cfg_busy` first rises, `sys_rst` is 1. A state machine reset by `sys_rst` stays in its initial state whenever either input is in its not-ready condition.
- R9: Once `sys_rst` is 0, it stays 0 for as long as `cfg_busy` is 0 and `pll_locked` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock for the release logic |
| cfg_busy | input | 1 | 1 while device configuration is still in progress |
| pll_locked | input | 1 | PLL lock indication, asynchronous to `clk` |
| pll_rst | output | 1 | Reset to the PLL, follows `cfg_busy` |
| sys_rst | output | 1 | Active-high system reset for user logic |

## Verification
The bound checker examines the following on every rising edge:

- The system reset is high whenever configuration is in progress or lock is absent.
- The reset stays low while both conditions persist.
- Any fall of the reset is preceded by at least the full synchronizer-plus-stretch count of ready cycles.
- A returning lock always finds the reset still asserted.

Some behaviour only the bench's scenarios can show. One is the exact edge at which release happens. Another is that assertion lands mid-cycle, before any clock edge. A third is the combinational path from `cfg_busy` to the PLL reset. The last is that a downstream state machine stays frozen in its initial state throughout early-lock, lock-loss and configuration re-entry sequences.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int unsigned CRS_DEF_STRETCH = 16;
  localparam int unsigned CRS_DEF_SYNC    = 2;

  // Counter width able to hold values 0..n
  function automatic int unsigned crs_cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/crs_bit_sync.sv
// Multi-stage bit synchronizer with an asynchronous clear to a chosen level.
module crs_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        CLR_VAL = 1'b0
) (
  input  logic clk,
  input  logic aclr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge aclr) begin
        if (aclr) chain <= CLR_VAL;
        else      chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge aclr) begin
        if (aclr) chain <= {STAGES{CLR_VAL}};
        else      chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/crs_stretch.sv
// Holds the reset output for CYCLES clock cycles after the synchronized
// deassertion request arrives; preset asynchronously by hold.
module crs_stretch
  import crs_pkg::*;
#(
  parameter int unsigned CYCLES = CRS_DEF_STRETCH
) (
  input  logic clk,
  input  logic hold,
  input  logic req_rst,
  output logic rst_out
);
  localparam int unsigned CW = crs_cw(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          rst_q;

  always_ff @(posedge clk or posedge hold) begin
    if (hold) begin
      cnt   <= '0;
      rst_q <= 1'b1;
    end else if (!req_rst && rst_q) begin
      if (cnt == LAST) rst_q <= 1'b0;
      else             cnt   <= cnt + 1'b1;
    end
  end

  assign rst_out = rst_q;
endmodule

// File: rtl/cfg_reset_seq.sv
module cfg_reset_seq
  import crs_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = CRS_DEF_STRETCH,
  parameter int unsigned SYNC_STAGES    = CRS_DEF_SYNC
) (
  input  logic clk,
  input  logic cfg_busy,
  input  logic pll_locked,
  output logic pll_rst,
  output logic sys_rst
);
  logic hold_async;
  logic lock_s;
  logic rst_sync;

  // PLL stays in reset until every region is out of configuration
  assign pll_rst    = cfg_busy;
  // Either failing condition forces reset immediately
  assign hold_async = cfg_busy | ~pll_locked;

  // Lock indication brought into the user domain; cleared while configuring
  crs_bit_sync #(
    .STAGES (SYNC_STAGES),
    .CLR_VAL(1'b0)
  ) u_lock_sync (
    .clk (clk),
    .aclr(cfg_busy),
    .d   (pll_locked),
    .q   (lock_s)
  );

  // Asynchronous assert, synchronous deassert
  crs_bit_sync #(
    .STAGES (SYNC_STAGES),
    .CLR_VAL(1'b1)
  ) u_rst_sync (
    .clk (clk),
    .aclr(hold_async),
    .d   (~lock_s),
    .q   (rst_sync)
  );

  crs_stretch #(
    .CYCLES(STRETCH_CYCLES)
  ) u_stretch (
    .clk    (clk),
    .hold   (hold_async),
    .req_rst(rst_sync),
    .rst_out(sys_rst)
  );
endmodule

// File: rtl/crs_chk.sv
module crs_chk #(
  parameter int unsigned STRETCH = 16,
  parameter int unsigned SYNC    = 2
) (
  input logic clk,
  input logic cfg_busy,
  input logic pll_locked,
  input logic pll_rst,
  input logic sys_rst
);
  localparam int unsigned MIN_READY = STRETCH + 2 * SYNC;

  logic [15:0] rdy_cnt;
  logic        ready;

  assign ready = !cfg_busy && pll_locked;

  // Consecutive ready cycles, saturating
  always_ff @(posedge clk) begin
    if (!ready)                rdy_cnt <= '0;
    else if (rdy_cnt != '1)    rdy_cnt <= rdy_cnt + 1'b1;
  end

  always @(posedge clk) begin
    // R2
    busy_holds_rst_chk: assert (!cfg_busy || sys_rst)
      else $error("sys_rst low while configuration busy");
    // R3
    nolock_holds_rst_chk: assert (pll_locked || sys_rst)
      else $error("sys_rst low while PLL unlocked");
  end

  // R6
  stretch_min_chk: assert property (@(posedge clk) disable iff (cfg_busy)
    $fell(sys_rst) |-> (rdy_cnt >= 16'(MIN_READY)));

  // R9
  stay_released_chk: assert property (@(posedge clk) disable iff (cfg_busy)
    (!sys_rst && pll_locked) |=> (!sys_rst || !pll_locked));

  // R7
  relock_in_rst_chk: assert property (@(posedge clk) disable iff (cfg_busy)
    $rose(pll_locked) |-> sys_rst);
endmodule

bind cfg_reset_seq crs_chk #(
  .STRETCH(STRETCH_CYCLES),
  .SYNC   (SYNC_STAGES)
) u_crs_chk (
  .clk       (clk),
  .cfg_busy  (cfg_busy),
  .pll_locked(pll_locked),
  .pll_rst   (pll_rst),
  .sys_rst   (sys_rst)
);

// File: tb/tb_cfg_reset_seq.sv
module tb_cfg_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 16;
  localparam int LATENCY    = STRETCH + 4;

  logic clk = 1'b0;
  logic cfg_busy = 1'b0;
  logic pll_locked = 1'b1;
  logic pll_rst, sys_rst;

  int n_chk = 0;
  int n_fail = 0;
  int ecnt = 0;
  bit running = 1'b0;
  bit after_loss = 1'b0;
  bit finished = 1'b0;
  logic [1:0] fsm_st;

  cfg_reset_seq #(.STRETCH_CYCLES(STRETCH)) dut (
    .clk(clk), .cfg_busy(cfg_busy), .pll_locked(pll_locked),
    .pll_rst(pll_rst), .sys_rst(sys_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Downstream state machine held by the system reset (R8 observer)
  always_ff @(posedge clk or posedge sys_rst) begin
    if (sys_rst) fsm_st <= 2'd0;
    else         fsm_st <= (fsm_st == 2'd3) ? 2'd1 : fsm_st + 2'd1;
  end

  function automatic bit is_ready(input logic b, input logic l);
    return !b && l;
  endfunction

  function automatic logic exp_rst(input logic b, input logic l, input int e);
    return !is_ready(b, l) || (e < LATENCY);
  endfunction

  // Model: rising edges seen with both conditions holding
  always @(posedge clk) begin
    if (!is_ready(cfg_busy, pll_locked)) ecnt = 0;
    else if (ecnt < 100000) ecnt = ecnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic b, input logic l, input int e, input bit lost);
    if (b && l) return "R4";
    if (b)      return "R2";
    if (!l)     return "R3";
    if (e < LATENCY) return lost ? "R7" : "R6";
    return "R9";
  endfunction

  // Per-cycle checks, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      logic e;
      e = exp_rst(cfg_busy, pll_locked, ecnt);
      chk(sys_rst === e, tag_of(cfg_busy, pll_locked, ecnt, after_loss), int'(sys_rst), int'(e));
      chk(pll_rst === cfg_busy, "R1", int'(pll_rst), int'(cfg_busy));
      if (!is_ready(cfg_busy, pll_locked))
        chk(fsm_st === 2'd0, "R8", int'(fsm_st), 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic drop_lock();
    pll_locked = 1'b0;
    #1;
    chk(sys_rst === 1'b1, "R5", int'(sys_rst), 1);
    if (ecnt >= LATENCY) after_loss = 1'b1;
  endtask

  task automatic raise_busy();
    cfg_busy = 1'b1;
    #1;
    chk(sys_rst === 1'b1, "R5", int'(sys_rst), 1);
    chk(pll_rst === 1'b1, "R1", int'(pll_rst), 1);
    after_loss = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int unsigned seed;
    int fall_edge;
    seed = 32'd20240611;
    void'($urandom(seed));

    // Power-up: no reliance on register initial values (R8)
    #1;
    cfg_busy   = 1'b1;
    pll_locked = 1'b0;
    #1;
    chk(sys_rst === 1'b1, "R8", int'(sys_rst), 1);
    chk(pll_rst === 1'b1, "R1", int'(pll_rst), 1);
    running = 1'b1;
    step(5);

    // Early lock while configuration still busy (R4)
    pll_locked = 1'b1;
    step(30);
    chk(sys_rst === 1'b1, "R4", int'(sys_rst), 1);

    // Configuration completes: exact release edge (R6)
    cfg_busy = 1'b0;
    fall_edge = 0;
    for (int i = 1; i <= LATENCY + 5; i++) begin
      @(posedge clk);
      #1;
      if (sys_rst === 1'b0 && fall_edge == 0) fall_edge = i;
    end
    chk(fall_edge == LATENCY, "R6", fall_edge, LATENCY);
    #(CLK_PERIOD/4 - 1);
    step(10);

    // Lock loss and full restart (R7)
    drop_lock();
    step(5);
    pll_locked = 1'b1;
    step(LATENCY - 2);
    chk(sys_rst === 1'b1, "R7", int'(sys_rst), 1);
    step(4);
    chk(sys_rst === 1'b0, "R7", int'(sys_rst), 0);

    // Configuration re-entry while locked (R2)
    raise_busy();
    step(6);
    cfg_busy = 1'b0;
    step(LATENCY + 3);

    // Random phase
    for (int it = 0; it < 250; it++) begin
      int sel;
      sel = int'($urandom % 4);
      if (sel == 0) begin
        raise_busy();
        if ($urandom % 2 == 0) pll_locked = 1'b0;
        step(3 + int'($urandom % 10));
        if ($urandom % 2 == 0) pll_locked = 1'b1;
        step(1 + int'($urandom % 4));
        cfg_busy = 1'b0;
        if (!pll_locked) begin
          step(3 + int'($urandom % 5));
          pll_locked = 1'b1;
        end
      end else if (pll_locked) begin
        drop_lock();
        step(3 + int'($urandom % 12));
        pll_locked = 1'b1;
      end
      step(int'($urandom % 40));
    end

    step(LATENCY + 2);
    running = 1'b0;
    summary();
  end
endmodule